// File: doc/BRIEF.md
# Variable-Length Parcel Issue Stage

This stage sits between an instruction parcel source and the issue logic of a processor. Parcels arrive 16 bits at a time. An instruction is either one parcel or two parcels that form 32 bits. The stage packs them into whole instructions and offers each one for issue. Every parcel lands first in a one-entry prefetch register. The leading parcel of an instruction then moves into a current register. When the instruction is long, its trailing parcel follows through the prefetch register into a lower register.

An assembled instruction waits in the current and lower registers until an external signal reports that the resources it needs are free. Nothing can cancel it once it is there, so instructions leave in exactly the order their parcels arrived. The length of an instruction comes from an opcode field at the top of its first parcel. No other decoding is done.

Top module: `pis_issue_stage`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `issue_valid` is 0 and `parcel_ready` is 1.
- R2: An instruction is long (two parcels) when the field in bits [15:12] of its first parcel is 12 or more as an unsigned number. Otherwise it is short. `issue_long` reports this for the offered instruction.
- R3: A short instruction is offered with its parcel in `issue_instr[31:16]`, zero in `issue_instr[15:0]`, and `issue_long` = 0.
- R4: A long instruction is offered with its first parcel in `issue_instr[31:16]`, its second parcel in `issue_instr[15:0]`, and `issue_long` = 1.
- R5: Every accepted instruction is offered exactly once, in arrival order. No instruction is lost or duplicated, whatever the timing of the parcel source and of `res_ready`.
- R6: While `res_ready` is 0, nothing issues. A blocked instruction stays offered, unchanged, until it issues.
- R7: A long instruction whose second parcel has not yet arrived is never offered, however long the parcel source stalls.
- R8: A parcel is consumed only on a cycle where `parcel_valid` and `parcel_ready` are both 1. When issue is blocked, the stage stops accepting once it holds a complete instruction plus one prefetched parcel: 2 parcels for short instructions and 3 for a long one.
- R9: Starting from an empty stage with `res_ready` high, an instruction whose last parcel is consumed at clock edge k is offered in the cycle after edge k+1, and not before.
- R10: With the source always valid and `res_ready` always 1, `parcel_ready` never drops, so one parcel is consumed every cycle for any mix of lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| parcel_valid | input | 1 | Source offers a parcel |
| parcel_data | input | 16 | Offered parcel |
| parcel_ready | output | 1 | Stage consumes the offered parcel this cycle |
| res_ready | input | 1 | Resources for the waiting instruction are free |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_instr | output | 32 | Issued instruction, first parcel in the upper half |
| issue_long | output | 1 | Issued instruction is two parcels long |

## Verification
The checker assumes that the source follows the valid/ready rule: a parcel counts only when both signals are high. It also assumes that `res_ready` may change freely from cycle to cycle. The bench drives every input half a cycle away from the active edge. It advances its own parcel pointer only on a cycle where it saw `parcel_ready` high, so it never relies on a parcel the stage did not take. The streams cycle through all sixteen opcode field values. Source gaps and resource stalls follow a fixed shift-register sequence, a regular cadence, or a long hold, and all of these stay inside those assumptions.

// File: rtl/pis_pkg.sv
// Package: shared defaults for the parcel issue stage.
// Assumes: parcels are 16 bits and long instructions span exactly two parcels.
package pis_pkg;
    localparam int PIS_PARCEL_W = 16;  // bits per parcel
    localparam int PIS_OPC_W    = 4;   // length field width at top of a parcel
    localparam int PIS_LONG_MIN = 12;  // smallest field value meaning "two parcels"
endpackage

// File: rtl/pis_len_dec.sv
// Module: length decoder. Looks at the opcode field in the top bits of a
// leading parcel and flags it as the head of a two-parcel instruction.
// Assumes: the field sits in the most significant OPC_W bits of the parcel.
module pis_len_dec #(
    parameter int PW       = pis_pkg::PIS_PARCEL_W,
    parameter int OPC_W    = pis_pkg::PIS_OPC_W,
    parameter int LONG_MIN = pis_pkg::PIS_LONG_MIN
) (
    input  logic [PW-1:0] parcel,
    output logic          is_long
);
    logic [OPC_W-1:0] field;

    // Pick the opcode field and compare it against the long threshold.
    always_comb begin
        field   = parcel[PW-1 -: OPC_W];
        is_long = (field >= OPC_W'(LONG_MIN));
    end
endmodule

// File: rtl/pis_prefetch.sv
// Module: one-entry prefetch register (the "next parcel" slot).
// Takes a parcel from the source whenever it is empty or being drained in
// the same cycle. Holds its content when the downstream slots are busy.
// Assumes: `take` is only asserted while the slot is valid.
module pis_prefetch #(
    parameter int PW = pis_pkg::PIS_PARCEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [PW-1:0] in_data,
    output logic          in_ready,
    input  logic          take,
    output logic          nxt_v,
    output logic [PW-1:0] nxt_data
);
    // Free when empty or emptied by the downstream move this cycle.
    always_comb in_ready = !nxt_v || take;

    // Load a new parcel or go empty whenever the slot is free; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_v    <= 1'b0;
            nxt_data <= '0;
        end else if (in_ready) begin
            nxt_v <= in_valid;
            if (in_valid) nxt_data <= in_data;
        end
    end
endmodule

// File: rtl/pis_hold.sv
// Module: current/lower instruction registers and issue control.
// The prefetched parcel moves into the current slot when that slot frees up.
// When the current slot holds the head of a long instruction, the next
// prefetched parcel moves into the lower slot instead. A complete
// instruction issues only when res_ready is high and is never dropped.
// Assumes: nxt_long is the decoded length of nxt_data.
module pis_hold #(
    parameter int PW = pis_pkg::PIS_PARCEL_W,
    localparam int IW = 2 * PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nxt_v,
    input  logic [PW-1:0] nxt_data,
    input  logic          nxt_long,
    input  logic          res_ready,
    output logic          take,
    output logic          complete,
    output logic          issue_valid,
    output logic [IW-1:0] issue_instr,
    output logic          issue_long
);
    logic          cur_v, cur_long, low_v;
    logic [PW-1:0] cur_q, low_q;
    logic          fire, to_cur, to_low;

    // Decide the issue and which slot, if any, the prefetched parcel enters.
    always_comb begin
        complete = cur_v && (!cur_long || low_v);
        fire     = complete && res_ready;
        to_low   = nxt_v && cur_v && cur_long && !low_v;
        to_cur   = nxt_v && (!cur_v || fire);
        take     = to_low || to_cur;
    end

    // Present the held instruction; the low half is zero for short ones.
    always_comb begin
        issue_valid = fire;
        issue_long  = cur_long;
        issue_instr = {cur_q, cur_long ? low_q : {PW{1'b0}}};
    end

    // Retire on issue, then refill the current or lower slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_v    <= 1'b0;
            cur_long <= 1'b0;
            low_v    <= 1'b0;
            cur_q    <= '0;
            low_q    <= '0;
        end else begin
            if (fire) begin
                cur_v <= 1'b0;
                low_v <= 1'b0;
            end
            if (to_cur) begin
                cur_v    <= 1'b1;
                cur_long <= nxt_long;
                cur_q    <= nxt_data;
            end
            if (to_low) begin
                low_v <= 1'b1;
                low_q <= nxt_data;
            end
        end
    end
endmodule

// File: rtl/pis_issue_stage.sv
// Module: variable-length parcel issue stage (top).
// Chains prefetch register -> length decode -> current/lower hold and issue.
// Assumes: the source keeps data stable only for the cycle it is consumed.
module pis_issue_stage #(
    parameter int PW       = pis_pkg::PIS_PARCEL_W,
    parameter int OPC_W    = pis_pkg::PIS_OPC_W,
    parameter int LONG_MIN = pis_pkg::PIS_LONG_MIN,
    localparam int IW = 2 * PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          parcel_valid,
    input  logic [PW-1:0] parcel_data,
    output logic          parcel_ready,
    input  logic          res_ready,
    output logic          issue_valid,
    output logic [IW-1:0] issue_instr,
    output logic          issue_long
);
    logic          nxt_v, nxt_long, take, held_complete;
    logic [PW-1:0] nxt_data;

    pis_prefetch #(.PW(PW)) u_pref (
        .clk(clk), .rst_n(rst_n),
        .in_valid(parcel_valid), .in_data(parcel_data), .in_ready(parcel_ready),
        .take(take), .nxt_v(nxt_v), .nxt_data(nxt_data)
    );

    pis_len_dec #(.PW(PW), .OPC_W(OPC_W), .LONG_MIN(LONG_MIN)) u_dec (
        .parcel(nxt_data), .is_long(nxt_long)
    );

    pis_hold #(.PW(PW)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .nxt_v(nxt_v), .nxt_data(nxt_data), .nxt_long(nxt_long),
        .res_ready(res_ready), .take(take), .complete(held_complete),
        .issue_valid(issue_valid), .issue_instr(issue_instr), .issue_long(issue_long)
    );
endmodule

// File: rtl/pis_issue_chk.sv
// Module: protocol checker bound to the issue stage.
// Assumes: inputs are sampled at the rising edge and reset is synchronous.
module pis_issue_chk #(
    parameter int PW       = pis_pkg::PIS_PARCEL_W,
    parameter int OPC_W    = pis_pkg::PIS_OPC_W,
    parameter int LONG_MIN = pis_pkg::PIS_LONG_MIN
) (
    input logic            clk,
    input logic            rst_n,
    input logic            parcel_valid,
    input logic            parcel_ready,
    input logic            res_ready,
    input logic            issue_valid,
    input logic [2*PW-1:0] issue_instr,
    input logic            issue_long,
    input logic            nxt_v,
    input logic            held_complete
);
    AST_ISSUE_NEEDS_RES: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> res_ready);  // R6
    AST_BLOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (held_complete && !res_ready) |=> (held_complete && $stable(issue_instr) && $stable(issue_long)));  // R6
    AST_LEN_MATCHES_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (issue_long == (issue_instr[2*PW-1 -: OPC_W] >= OPC_W'(LONG_MIN))));  // R2
    AST_SHORT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !issue_long) |-> (issue_instr[PW-1:0] == '0));  // R3
    AST_ACCEPT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (parcel_valid && parcel_ready) |=> nxt_v);  // R8
    AST_NO_DUP_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !nxt_v) |=> !issue_valid);  // R5
endmodule

bind pis_issue_stage pis_issue_chk #(.PW(PW), .OPC_W(OPC_W), .LONG_MIN(LONG_MIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .parcel_valid(parcel_valid), .parcel_ready(parcel_ready),
    .res_ready(res_ready), .issue_valid(issue_valid), .issue_instr(issue_instr),
    .issue_long(issue_long), .nxt_v(nxt_v), .held_complete(held_complete)
);

// File: tb/sim_pis_issue_stage.sv
`timescale 1ns/1ps
module sim_pis_issue_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        parcel_valid = 1'b0;
    logic [15:0] parcel_data = '0;
    logic        parcel_ready;
    logic        res_ready = 1'b0;
    logic        issue_valid;
    logic [31:0] issue_instr;
    logic        issue_long;

    always #2.5 clk = ~clk;

    pis_issue_stage u0 (
        .clk(clk), .rst_n(rst_n), .parcel_valid(parcel_valid), .parcel_data(parcel_data),
        .parcel_ready(parcel_ready), .res_ready(res_ready), .issue_valid(issue_valid),
        .issue_instr(issue_instr), .issue_long(issue_long)
    );

    int checks = 0;
    int fails  = 0;
    logic [15:0] par  [0:1023];
    logic [31:0] expi [0:511];
    logic        expl [0:511];
    int npar = 0, nexp = 0, src_idx = 0, exp_idx = 0, cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Build the stream: all 16 field values recur, long ones get a second parcel.
    task automatic build_stream();
        for (int j = 0; j < 480; j++) begin
            logic [3:0]  op;
            logic [15:0] p1, p2;
            op = 4'((j * 5 + j / 16) % 16);
            p1 = {op, 12'(j)};
            par[npar] = p1; npar++;
            if (op >= 4'd12) begin
                p2 = {8'(j), 8'(j)} ^ 16'h5A3C;
                par[npar] = p2; npar++;
                expi[nexp] = {p1, p2}; expl[nexp] = 1'b1;
            end else begin
                expi[nexp] = {p1, 16'h0000}; expl[nexp] = 1'b0;
            end
            nexp++;
        end
    endtask

    // Run the stream with a given source/resource pattern until `upto` issues.
    task automatic run_phase(input int vm, input int rm, input int upto);
        int  guard = 0;
        bit  drop = 1'b0;
        bit  pv;
        while (exp_idx < upto && guard < 20000) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pv = (src_idx < npar) && (vm == 0 || (vm == 1 && lfsr[0]) || (vm == 2 && cyc % 3 == 0));
            parcel_valid = pv;
            parcel_data  = pv ? par[src_idx] : 16'h0;
            res_ready = (rm == 0) || (rm == 1 && lfsr[3]) || (rm == 2 && (cyc % 10) >= 8);
            #0.5;
            if (issue_valid) begin
                if (exp_idx < nexp) begin
                    chk(issue_instr == expi[exp_idx], "R5 order/content", issue_instr, expi[exp_idx]);
                    chk(issue_long == expl[exp_idx], "R2 length flag", 32'(issue_long), 32'(expl[exp_idx]));
                end else begin
                    chk(1'b0, "R5 extra issue", issue_instr, 32'h0);
                end
                exp_idx++;
            end
            if (!res_ready) chk(!issue_valid, "R6 issue while blocked", 32'(issue_valid), 32'h0);
            if (vm == 0 && rm == 0 && src_idx < npar && !parcel_ready) drop = 1'b1;
            if (pv && parcel_ready) src_idx++;
            guard++; cyc++;
        end
        chk(exp_idx >= upto, "R5 all issued", 32'(exp_idx), 32'(upto));
        if (vm == 0 && rm == 0) chk(!drop, "R10 ready stayed high", 32'(drop), 32'h0);
    endtask

    // Fill against a blocked issue, count accepts, then release and check order.
    task automatic bp_test(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                           input logic [15:0] d, input int n, input int exp_acc,
                           input logic [31:0] e0, input logic [31:0] e1);
        logic [15:0] src [0:3];
        int acc = 0, got = 0;
        src[0] = a; src[1] = b; src[2] = c; src[3] = d;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            res_ready = 1'b0;
            parcel_valid = (acc < n);
            parcel_data  = (acc < n) ? src[acc] : 16'h0;
            #0.5;
            if (parcel_valid && parcel_ready) acc++;
        end
        chk(acc == exp_acc, "R8 accepted while blocked", 32'(acc), 32'(exp_acc));
        chk(!parcel_ready || acc == n, "R8 ready low when full", 32'(parcel_ready), 32'h0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            res_ready = 1'b1;
            parcel_valid = (acc < n);
            parcel_data  = (acc < n) ? src[acc] : 16'h0;
            #0.5;
            if (parcel_valid && parcel_ready) acc++;
            if (issue_valid) begin
                if (got == 0) chk(issue_instr == e0, "R5 first after release", issue_instr, e0);
                else if (got == 1) chk(issue_instr == e1, "R5 second after release", issue_instr, e1);
                got++;
            end
        end
        chk(got == 2, "R8 nothing consumed in excess", 32'(got), 32'd2);
        parcel_valid = 1'b0;
    endtask

    initial begin
        build_stream();
        repeat (3) @(negedge clk);
        #0.5;
        chk(!issue_valid && parcel_ready, "R1 during reset", {30'h0, issue_valid, parcel_ready}, 32'h1);
        @(negedge clk);
        rst_n = 1'b1;
        res_ready = 1'b1;
        @(negedge clk); #0.5;
        chk(!issue_valid && parcel_ready, "R1 after reset", {30'h0, issue_valid, parcel_ready}, 32'h1);

        // R9 / R3: single short parcel on an empty stage.
        @(negedge clk);
        parcel_valid = 1'b1; parcel_data = 16'h1234;
        @(negedge clk);
        parcel_valid = 1'b0; #0.5;
        chk(!issue_valid, "R9 short not early", 32'(issue_valid), 32'h0);
        @(negedge clk); #0.5;
        chk(issue_valid && issue_instr == 32'h12340000 && !issue_long, "R3 short issue",
            issue_instr, 32'h12340000);

        // R7 / R4 / R9: long head, then source stall, then tail.
        @(negedge clk);
        parcel_valid = 1'b1; parcel_data = 16'hC0DE;
        @(negedge clk);
        parcel_valid = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #0.5;
            chk(!issue_valid, "R7 half instruction held", 32'(issue_valid), 32'h0);
        end
        @(negedge clk);
        parcel_valid = 1'b1; parcel_data = 16'hBEEF;
        @(negedge clk);
        parcel_valid = 1'b0; #0.5;
        chk(!issue_valid, "R9 long not early", 32'(issue_valid), 32'h0);
        @(negedge clk); #0.5;
        chk(issue_valid && issue_instr == 32'hC0DEBEEF && issue_long, "R4 long issue",
            issue_instr, 32'hC0DEBEEF);
        @(negedge clk);

        // R8: backpressure, short then long.
        bp_test(16'h2001, 16'h2002, 16'h0, 16'h0, 2, 2, 32'h20010000, 32'h20020000);
        bp_test(16'hE001, 16'h0002, 16'hE003, 16'h0004, 4, 3, 32'hE0010002, 32'hE0030004);

        // Stream sweeps over source and resource patterns.
        run_phase(0, 0, 120);
        run_phase(1, 1, 240);
        run_phase(2, 0, 330);
        run_phase(0, 2, 400);
        run_phase(1, 0, nexp);
        chk(src_idx == npar, "R5 all parcels consumed", 32'(src_idx), 32'(npar));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", exp_idx, nexp);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule